// File: doc/BRIEF.md
# Response Reorder Buffer for a Chained Register Bus

This block sits between the per-chain response queues of a ring bus controller and the requester. Each request the controller issues is given a transaction tag by this block. The tag is the lowest free one, and it stays unique while the transaction is open. Responses come back from the chains in any order. The block parks them in an external one-cycle-latency memory, with each transaction's words threaded into its own linked list. It then hands read data and read errors back strictly in the order the reads were issued.

Write transactions never reach the data port. A successful write completion is swallowed. A failed write is turned into an interrupt record that carries the tag and the returned word. Interrupt messages from the chains skip the reorder machinery and reach the interrupt port in arrival order. Admission of new work is limited in two ways: by the number of open tags, and by the number of responses still owed, which must fit in the memory depth.

Top module: `rsp_reorder`

## Requirements
- R1: At most TXN_MAX transactions are open at once. `iss_ready` is low while every tag is in use. A granted tag (`iss_id`) is never one that is still open.
- R2: A read of `iss_len`+1 words reserves `iss_len`+1 response slots, and a write reserves 1. A request is granted only if the slots it reserves plus the slots still reserved stay at or below MEM_DEPTH.
- R3: Read responses leave on `rsp_*` in read issue order, whatever order the chains return them in. A later read's data is held back until every earlier read has been delivered in full.
- R4: Within one read, words are delivered in the order they arrived.
- R5: A write completion of kind OK (`in_kind`=0) produces nothing on `rsp_*` or `irq_*`, and it frees the tag.
- R6: A write completion of kind ERR (`in_kind`=1) raises `irq_req` with `irq_status` = {1'b1, tag, data}. The MSB is the source bit, the tag sits in the next ID_W bits, and the data occupies the low DATA_W bits.
- R7: A chain interrupt (`in_kind`=2) raises `irq_req` on the clock edge that accepts it, with `irq_status` = {1'b0, `in_id`, `in_data`}, even while reads are pending. `irq_req` and `irq_status` hold until `irq_ack`, and `in_ready` is low while an interrupt waits.
- R8: A read ERR response is delivered with `rsp_error`=1 after the words that preceded it. It ends that read, so no further words are expected, and its tag and unused reservations are released.
- R9: Once `rsp_valid` is high, `rsp_valid`, `rsp_data` and `rsp_error` hold until `rsp_ack`.
- R10: Stored words are read with `mem_re` and taken from `mem_rdata` one cycle later. Every entry is returned for reuse when its word is delivered, so the full depth can be filled again and again. The block never reads and writes the same address in one cycle.
- R11: After reset, `rsp_valid` and `irq_req` are low and `iss_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | Controller wants to issue a request |
| iss_write | input | 1 | 1 = write, 0 = read |
| iss_len | input | SIZE_W | Burst length minus one (reads) |
| iss_ready | output | 1 | Request granted this cycle when iss_valid |
| iss_id | output | ID_W | Tag given to the granted request |
| in_valid | input | 1 | Response from a chain queue is present |
| in_kind | input | 2 | 0 OK, 1 ERR, 2 interrupt |
| in_id | input | ID_W | Tag of the response (interrupt: source number) |
| in_data | input | DATA_W | Read word, error word or interrupt vector |
| in_ready | output | 1 | Response accepted this cycle when in_valid |
| rsp_valid | output | 1 | Ordered read response present |
| rsp_error | output | 1 | Response is an error |
| rsp_data | output | DATA_W | Read word |
| rsp_ack | input | 1 | Consumer takes the response |
| irq_req | output | 1 | Interrupt record present |
| irq_status | output | 1+ID_W+DATA_W | {source, tag, data} |
| irq_ack | input | 1 | Interrupt record taken |
| mem_we | output | 1 | Store write enable |
| mem_waddr | output | PTR_W | Store write address |
| mem_wdata | output | DATA_W+1 | {error flag, word} |
| mem_re | output | 1 | Store read enable |
| mem_raddr | output | PTR_W | Store read address |
| mem_rdata | input | DATA_W+1 | Store read data, one cycle after mem_re |

## Verification
The bench goes after responses that arrive in reverse order: a buffer that forwarded in arrival order would hand the younger read's word out first. It fills the store to its exact depth twice. A design that leaked entries, or got the head and tail hand-off wrong when a list runs empty, would stall or send out stale words. It cuts a burst short with an error and then reissues the full set of tags. A design that missed releasing the tag or the unused reservations would then refuse grants it owes. It also checks that write completions never reach the data port and that a chain interrupt overtakes a pending read.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [1:0] {
        RK_OK   = 2'd0,
        RK_ERR  = 2'd1,
        RK_INTR = 2'd2
    } rsp_kind_e;

    // source bit carried at the top of an interrupt record
    localparam logic SRC_CHAIN = 1'b0;
    localparam logic SRC_WRERR = 1'b1;
endpackage

// File: rtl/lowbit_pick.sv
module lowbit_pick #(
    parameter int N = 4,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] avail,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        any = |avail;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (avail[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/id_queue.sv
module id_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 2,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;

    assign empty = (cnt == '0);
    assign dout  = slots[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                slots[wp] <= din;
                wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
        end
    end
endmodule

// File: rtl/rsp_reorder.sv
module rsp_reorder
    import rob_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SIZE_W    = 3,
    parameter int TXN_MAX   = 4,
    parameter int MEM_DEPTH = 16,
    localparam int ID_W  = $clog2(TXN_MAX),
    localparam int PTR_W = $clog2(MEM_DEPTH),
    localparam int CNT_W = $clog2(MEM_DEPTH + 1) + 1,
    localparam int MW_W  = DATA_W + 1,
    localparam int ST_W  = 1 + ID_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic              iss_write,
    input  logic [SIZE_W-1:0] iss_len,
    output logic              iss_ready,
    output logic [ID_W-1:0]   iss_id,
    input  logic              in_valid,
    input  logic [1:0]        in_kind,
    input  logic [ID_W-1:0]   in_id,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              rsp_valid,
    output logic              rsp_error,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              rsp_ack,
    output logic              irq_req,
    output logic [ST_W-1:0]   irq_status,
    input  logic              irq_ack,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_waddr,
    output logic [MW_W-1:0]   mem_wdata,
    output logic              mem_re,
    output logic [PTR_W-1:0]  mem_raddr,
    input  logic [MW_W-1:0]   mem_rdata
);
    // per-tag state
    logic [TXN_MAX-1:0] t_busy, t_wr;
    logic [CNT_W-1:0]   t_pend [TXN_MAX];
    logic [CNT_W-1:0]   t_left [TXN_MAX];
    logic [CNT_W-1:0]   t_cnt  [TXN_MAX];
    logic [PTR_W-1:0]   t_head [TXN_MAX];
    logic [PTR_W-1:0]   t_tail [TXN_MAX];
    // per-entry state
    logic [PTR_W-1:0]     link [MEM_DEPTH];
    logic [MEM_DEPTH-1:0] errb, free_map;
    logic [CNT_W-1:0]     resv, resv_nxt;
    logic                 rd_pend;

    logic             id_any, ent_any, hq_empty;
    logic [ID_W-1:0]  new_id, hq_id;
    logic [PTR_W-1:0] ent_new, fptr;
    logic [CNT_W-1:0] need, err_drop;
    logic             iss_fire, acc, is_intr, hit_wr, app, wr_err, in_err;
    logic             fetch, flast, fetch_same, list_empty;
    rsp_kind_e        kind;

    lowbit_pick #(.N(TXN_MAX))   u_tag_pick (.avail(~t_busy),  .any(id_any),  .idx(new_id));
    lowbit_pick #(.N(MEM_DEPTH)) u_ent_pick (.avail(free_map), .any(ent_any), .idx(ent_new));

    id_queue #(.DEPTH(TXN_MAX), .W(ID_W)) u_order (
        .clk(clk), .rst(rst),
        .push(iss_fire && !iss_write), .din(new_id),
        .pop(fetch && flast), .dout(hq_id), .empty(hq_empty)
    );

    always_comb begin
        need      = iss_write ? CNT_W'(1) : CNT_W'(iss_len) + CNT_W'(1);
        iss_ready = id_any && ((resv + need) <= CNT_W'(MEM_DEPTH));
        iss_id    = new_id;
        iss_fire  = iss_valid && iss_ready;

        kind     = rsp_kind_e'(in_kind);
        in_ready = !irq_req;
        acc      = in_valid && in_ready;
        in_err   = (kind == RK_ERR);
        is_intr  = acc && (kind == RK_INTR);
        hit_wr   = acc && !is_intr && t_wr[in_id];
        app      = acc && !is_intr && !t_wr[in_id] && ent_any;
        wr_err   = hit_wr && in_err;
        err_drop = (app && in_err) ? t_pend[in_id] - CNT_W'(1) : '0;

        fptr  = t_head[hq_id];
        fetch = !hq_empty && (t_cnt[hq_id] != '0) && !rd_pend && !rsp_valid;
        flast = errb[fptr] || (t_left[hq_id] == CNT_W'(1));
        fetch_same = fetch && (hq_id == in_id);
        list_empty = (t_cnt[in_id] - CNT_W'(fetch_same)) == '0;

        resv_nxt = resv + (iss_fire ? need : '0) - CNT_W'(fetch)
                 - CNT_W'(hit_wr) - err_drop;

        mem_we    = app;
        mem_waddr = ent_new;
        mem_wdata = {in_err, in_data};
        mem_re    = fetch;
        mem_raddr = fptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_busy   <= '0;
            t_wr     <= '0;
            free_map <= '1;
            resv     <= '0;
            rd_pend  <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_error <= 1'b0;
            rsp_data  <= '0;
            irq_req    <= 1'b0;
            irq_status <= '0;
            for (int i = 0; i < TXN_MAX; i++) t_cnt[i] <= '0;
        end else begin
            resv    <= resv_nxt;
            rd_pend <= fetch;

            if (iss_fire) begin
                t_busy[new_id] <= 1'b1;
                t_wr[new_id]   <= iss_write;
                t_pend[new_id] <= need;
                t_left[new_id] <= need;
            end
            if (hit_wr) t_busy[in_id] <= 1'b0;

            for (int i = 0; i < TXN_MAX; i++) begin
                t_cnt[i] <= t_cnt[i] + CNT_W'(app && (in_id == ID_W'(i)))
                                     - CNT_W'(fetch && (hq_id == ID_W'(i)));
            end

            if (fetch) begin
                t_head[hq_id]  <= link[fptr];
                t_left[hq_id]  <= t_left[hq_id] - CNT_W'(1);
                free_map[fptr] <= 1'b1;
                if (flast) t_busy[hq_id] <= 1'b0;
            end
            if (app) begin
                t_pend[in_id]     <= in_err ? '0 : t_pend[in_id] - CNT_W'(1);
                errb[ent_new]     <= in_err;
                free_map[ent_new] <= 1'b0;
                t_tail[in_id]     <= ent_new;
                if (list_empty) t_head[in_id] <= ent_new;
                else            link[t_tail[in_id]] <= ent_new;
            end

            if (rd_pend) begin
                rsp_valid <= 1'b1;
                rsp_error <= mem_rdata[DATA_W];
                rsp_data  <= mem_rdata[DATA_W-1:0];
            end else if (rsp_valid && rsp_ack) begin
                rsp_valid <= 1'b0;
            end

            if (irq_req && irq_ack) irq_req <= 1'b0;
            if (is_intr) begin
                irq_req    <= 1'b1;
                irq_status <= {SRC_CHAIN, in_id, in_data};
            end else if (wr_err) begin
                irq_req    <= 1'b1;
                irq_status <= {SRC_WRERR, in_id, in_data};
            end
        end
    end
endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
    parameter int TXN_MAX   = 4,
    parameter int MEM_DEPTH = 16,
    parameter int DATA_W    = 8,
    parameter int ID_W      = 2,
    parameter int PTR_W     = 4,
    parameter int CNT_W     = 6,
    parameter int ST_W      = 11
) (
    input logic               clk,
    input logic               rst,
    input logic               iss_valid,
    input logic               iss_ready,
    input logic [ID_W-1:0]    iss_id,
    input logic [TXN_MAX-1:0] busy,
    input logic [CNT_W-1:0]   resv,
    input logic               rsp_valid,
    input logic               rsp_ack,
    input logic               rsp_error,
    input logic [DATA_W-1:0]  rsp_data,
    input logic               irq_req,
    input logic               irq_ack,
    input logic [ST_W-1:0]    irq_status,
    input logic               mem_we,
    input logic               mem_re,
    input logic [PTR_W-1:0]   mem_waddr,
    input logic [PTR_W-1:0]   mem_raddr
);
    assert_fresh_tag_R1: assert property (@(posedge clk) disable iff (rst)
        iss_valid && iss_ready |-> !busy[iss_id]);

    assert_resv_cap_R2: assert property (@(posedge clk) disable iff (rst)
        resv <= CNT_W'(MEM_DEPTH));

    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (rst)
        irq_req && !irq_ack |=> irq_req && $stable(irq_status));

    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ack |=> rsp_valid && $stable(rsp_data) && $stable(rsp_error));

    assert_mem_port_R10: assert property (@(posedge clk) disable iff (rst)
        mem_we && mem_re |-> mem_waddr != mem_raddr);
endmodule

bind rsp_reorder rob_chk #(
    .TXN_MAX(TXN_MAX), .MEM_DEPTH(MEM_DEPTH), .DATA_W(DATA_W),
    .ID_W(ID_W), .PTR_W(PTR_W), .CNT_W(CNT_W), .ST_W(ST_W)
) u_chk (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_id(iss_id), .busy(t_busy), .resv(resv),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_error(rsp_error),
    .rsp_data(rsp_data), .irq_req(irq_req), .irq_ack(irq_ack),
    .irq_status(irq_status), .mem_we(mem_we), .mem_re(mem_re),
    .mem_waddr(mem_waddr), .mem_raddr(mem_raddr)
);

// File: tb/tb_rsp_reorder.sv
module tb_rsp_reorder;
    localparam int DATA_W = 8, SIZE_W = 3, TXN_MAX = 4, MEM_DEPTH = 16;
    localparam int ID_W = 2, PTR_W = 4, MW_W = 9, ST_W = 11;

    logic clk = 1'b0, rst = 1'b1;
    logic iss_valid = 0, iss_write = 0;
    logic [SIZE_W-1:0] iss_len = '0;
    logic iss_ready;
    logic [ID_W-1:0] iss_id;
    logic in_valid = 0;
    logic [1:0] in_kind = '0;
    logic [ID_W-1:0] in_id = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic in_ready, rsp_valid, rsp_error, rsp_ack = 0;
    logic [DATA_W-1:0] rsp_data;
    logic irq_req, irq_ack = 0;
    logic [ST_W-1:0] irq_status;
    logic mem_we, mem_re;
    logic [PTR_W-1:0] mem_waddr, mem_raddr;
    logic [MW_W-1:0] mem_wdata, mem_rdata;
    logic [MW_W-1:0] store [MEM_DEPTH];

    int vectors = 0, miscompares = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    always_ff @(posedge clk) begin
        if (mem_we) store[mem_waddr] <= mem_wdata;
        if (mem_re) mem_rdata <= store[mem_raddr];
    end

    rsp_reorder #(.DATA_W(DATA_W), .SIZE_W(SIZE_W), .TXN_MAX(TXN_MAX), .MEM_DEPTH(MEM_DEPTH)) dut (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_write(iss_write),
        .iss_len(iss_len), .iss_ready(iss_ready), .iss_id(iss_id),
        .in_valid(in_valid), .in_kind(in_kind), .in_id(in_id), .in_data(in_data),
        .in_ready(in_ready), .rsp_valid(rsp_valid), .rsp_error(rsp_error),
        .rsp_data(rsp_data), .rsp_ack(rsp_ack), .irq_req(irq_req),
        .irq_status(irq_status), .irq_ack(irq_ack), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_re(mem_re),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input bit wr, input logic [SIZE_W-1:0] len, output logic [ID_W-1:0] id);
        @(negedge clk);
        iss_valid = 1; iss_write = wr; iss_len = len;
        while (!iss_ready) @(negedge clk);
        id = iss_id;
        @(posedge clk); #1 iss_valid = 0;
    endtask

    task automatic send(input logic [1:0] k, input logic [ID_W-1:0] id, input logic [DATA_W-1:0] d);
        @(negedge clk);
        in_valid = 1; in_kind = k; in_id = id; in_data = d;
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1 in_valid = 0;
    endtask

    task automatic get_rsp(input logic [DATA_W-1:0] d, input bit e, input string req);
        int n = 0;
        @(negedge clk);
        while (!rsp_valid && n < 60) begin @(negedge clk); n++; end
        check(rsp_valid, req, rsp_valid, 1);
        check(rsp_data == d && rsp_error == e, req, {rsp_error, rsp_data}, {e, d});
        rsp_ack = 1; @(posedge clk); #1 rsp_ack = 0;
    endtask

    task automatic quiet(input string req);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(!rsp_valid && !irq_req, req, {rsp_valid, irq_req}, 0);
        end
    endtask

    task automatic t_reset;   // R11
        check(!rsp_valid && !irq_req && iss_ready, "R11", {rsp_valid, irq_req, iss_ready}, 1);
    endtask

    task automatic t_reorder; // R3 R4 R10
        logic [ID_W-1:0] a, b;
        issue(0, 3'd1, a);
        issue(0, 3'd0, b);
        check(a != b, "R1", a, b + 1);
        send(0, b, 8'h22);
        quiet("R3 younger held");
        send(0, a, 8'h31);
        send(0, a, 8'h32);
        get_rsp(8'h31, 0, "R4");
        get_rsp(8'h32, 0, "R4");
        get_rsp(8'h22, 0, "R3");
    endtask

    task automatic t_write_ok; // R5
        logic [ID_W-1:0] w;
        issue(1, 3'd0, w);
        send(0, w, 8'h99);
        quiet("R5");
    endtask

    task automatic t_write_err; // R6
        logic [ID_W-1:0] w;
        issue(1, 3'd0, w);
        send(1, w, 8'h5A);
        @(negedge clk);
        check(irq_req && irq_status == {1'b1, w, 8'h5A}, "R6", irq_status, {1'b1, w, 8'h5A});
        check(!rsp_valid, "R6 no data", rsp_valid, 0);
        irq_ack = 1; @(posedge clk); #1 irq_ack = 0;
    endtask

    task automatic t_chain_irq; // R7
        logic [ID_W-1:0] a;
        issue(0, 3'd0, a);
        send(2, 2'd3, 8'h77);
        @(negedge clk);
        check(irq_req && irq_status == {1'b0, 2'd3, 8'h77}, "R7", irq_status, {1'b0, 2'd3, 8'h77});
        check(!in_ready, "R7 stall", in_ready, 0);
        @(negedge clk);
        check(irq_req, "R7 hold", irq_req, 1);
        irq_ack = 1; @(posedge clk); #1 irq_ack = 0;
        send(0, a, 8'h12);
        get_rsp(8'h12, 0, "R7 read after irq");
    endtask

    task automatic t_read_err; // R8
        logic [ID_W-1:0] a;
        issue(0, 3'd2, a);
        send(0, a, 8'h41);
        send(1, a, 8'h42);
        get_rsp(8'h41, 0, "R8");
        get_rsp(8'h42, 1, "R8");
        quiet("R8 burst ended");
    endtask

    task automatic t_hold; // R9
        logic [ID_W-1:0] a;
        issue(0, 3'd0, a);
        send(0, a, 8'hC3);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(rsp_valid && rsp_data == 8'hC3, "R9", rsp_data, 8'hC3);
        end
        get_rsp(8'hC3, 0, "R9");
    endtask

    task automatic t_tag_limit; // R1
        logic [ID_W-1:0] ids [4];
        for (int i = 0; i < 4; i++) issue(1, 3'd0, ids[i]);
        check(ids[0] != ids[1] && ids[0] != ids[2] && ids[0] != ids[3] &&
              ids[1] != ids[2] && ids[1] != ids[3] && ids[2] != ids[3], "R1", ids[3], 3);
        @(negedge clk);
        check(!iss_ready, "R1 full", iss_ready, 0);
        for (int i = 0; i < 4; i++) send(0, ids[i], 8'h00);
        @(negedge clk);
        check(iss_ready, "R1 freed", iss_ready, 1);
    endtask

    task automatic t_depth; // R2 R10
        logic [ID_W-1:0] a, b;
        for (int pass = 0; pass < 2; pass++) begin
            issue(0, 3'd7, a);
            issue(0, 3'd7, b);
            @(negedge clk);
            iss_write = 1; iss_len = '0;
            #1 check(!iss_ready, "R2 depth", iss_ready, 0);
            for (int i = 0; i < 8; i++) send(0, b, 8'hB0 + 8'(i) + 8'(pass));
            for (int i = 0; i < 8; i++) send(0, a, 8'hA0 + 8'(i) + 8'(pass));
            for (int i = 0; i < 8; i++) get_rsp(8'hA0 + 8'(i) + 8'(pass), 0, "R10");
            for (int i = 0; i < 8; i++) get_rsp(8'hB0 + 8'(i) + 8'(pass), 0, "R2");
            @(negedge clk);
            check(iss_ready, "R2 released", iss_ready, 1);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        t_reset;
        t_reorder;
        t_write_ok;
        t_write_err;
        t_chain_irq;
        t_read_err;
        t_hold;
        t_tag_limit;
        t_depth;
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            vectors++; miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule